// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel RGB video output. From a small bank of programmed values it derives horizontal sync, vertical sync and a data-enable strobe. It also raises a frame interrupt once the last displayed line of each frame has gone out. Software programs it through a simple write-only port. Each axis is described by four sizes: active, front porch, sync width and back porch. Each size is stored as its true length minus one, so a field of zero means a length of one.

Along each axis the segments follow in a fixed order: active, front porch, sync, back porch. The counters wrap to the first active pixel of the first active line after the last back-porch pixel of the last back-porch line. Programmed sizes are held in a staging bank. A shadow bank takes a copy of them only at a frame boundary, or at any time while timing is stopped. A frame that is already under way therefore always finishes with the sizes it started with. The frame interrupt is a level output driven by a pending bit. Software clears that bit by writing one to it.

Top module: `vtg_top`

## Requirements
- R1: After reset, hsync, vsync, de and frame_irq are all low, and they stay low until timing is enabled.
- R2: The active-width field (address 4) and the active-height field (address 8) hold the displayed pixel count minus one and the displayed line count minus one. Per frame, de is high for exactly width*height cycles.
- R3: The horizontal front porch, sync and back porch fields (addresses 5, 6, 7) each hold a length in pixels minus one. hsync is active-high. It first rises active-width plus front-porch cycles after the first de cycle of a frame. Each line it is high for sync-width cycles.
- R4: The vertical front porch, sync and back porch fields (addresses 9, 10, 11) hold line counts minus one. A frame lasts line-total times line-count cycles. vsync is active-high and rises at the start of line (active-height plus front porch). It stays high for sync-width whole lines.
- R5: Timing runs only when both bit 0 (video enable) and bit 1 (frame enable) of the control register at address 0 are set. With either bit clear, hsync, vsync and de are all low.
- R6: When timing is enabled again, it restarts at the first active pixel of the first line, so de is high in the first running cycle.
- R7: The frame interrupt pending bit is set at the first pixel of the first line after the last active line. This happens only when bit 0 (global enable) and bit 1 (frame enable) of the interrupt-enable register at address 1 are both set. frame_irq shows the pending bit.
- R8: Writing a value with bit 0 set to the pending register at address 2 clears the pending bit. Writing a value with bit 0 clear leaves it unchanged.
- R9: Size fields written during a frame do not affect that frame. They take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |
| de | output | 1 | Data enable, high inside the active region |
| frame_irq | output | 1 | Frame interrupt, level of the pending bit |

## Verification
Each frame is reduced to a summary: its length, the number of de, hsync and vsync cycles, and the cycle offsets of the first hsync rise, the vsync rise and the interrupt rise from the frame's first de cycle. Summaries are compared for three geometries. One is asymmetric and generous, one is smaller and differently shaped, and the third sets every field to zero. Between them they separate a missing or extra minus-one in any one segment, a swapped segment order, and an off-by-one wrap. A second geometry is written in the middle of a frame, which shows whether the shadow copy is taken at the frame boundary or immediately. Further directed steps hold one enable bit at a time, run with the interrupt enables partly cleared, and write zero and then one to the pending bit.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   // Register map: control, interrupt enables, interrupt pending, then the
   // per-axis size fields, horizontal axis first.
   localparam int REG_CTRL     = 0;
   localparam int REG_IRQ_EN   = 1;
   localparam int REG_IRQ_PEND = 2;
   localparam int FIELD_BASE   = 4;

   localparam int NUM_AXES     = 2;
   localparam int AXIS_FIELDS  = 4;

   // Field order inside one axis; also the segment order along that axis.
   localparam int F_ACT   = 0;
   localparam int F_FRONT = 1;
   localparam int F_SYNC  = 2;
   localparam int F_BACK  = 3;

   typedef enum logic [1:0] {
      SEG_ACTIVE = 2'd0,
      SEG_FRONT  = 2'd1,
      SEG_SYNC   = 2'd2,
      SEG_BACK   = 2'd3
   } seg_e;

   function automatic int field_addr(input int axis, input int field);
      return FIELD_BASE + axis * AXIS_FIELDS + field;
   endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
   import vtg_pkg::*;
#(
   parameter int FIELD_W = 12,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                frame_load,
   output logic                video_en,
   output logic                frame_en,
   output logic                irq_glb_en,
   output logic                irq_frm_en,
   output logic                pend_clr,
   output logic [NUM_AXES-1:0][AXIS_FIELDS-1:0][FIELD_W-1:0] shadow
);

   logic [NUM_AXES-1:0][AXIS_FIELDS-1:0][FIELD_W-1:0] staged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         video_en   <= 1'b0;
         frame_en   <= 1'b0;
         irq_glb_en <= 1'b0;
         irq_frm_en <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(REG_CTRL)) begin
            video_en <= wr_data[0];
            frame_en <= wr_data[1];
         end
         if (wr_addr == ADDR_W'(REG_IRQ_EN)) begin
            irq_glb_en <= wr_data[0];
            irq_frm_en <= wr_data[1];
         end
      end
   end

   assign pend_clr = wr_en && (wr_addr == ADDR_W'(REG_IRQ_PEND)) && wr_data[0];

   for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
      for (genvar f = 0; f < AXIS_FIELDS; f++) begin : g_field
         localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(field_addr(ax, f));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               staged[ax][f] <= '0;
            end else if (wr_en && wr_addr == MY_ADDR) begin
               staged[ax][f] <= wr_data[FIELD_W-1:0];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow[ax][f] <= '0;
            end else if (frame_load) begin
               shadow[ax][f] <= staged[ax][f];
            end
         end
      end
   end

   // R9: the sizes in use change only on a frame boundary or while stopped
   p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_load |=> $stable(shadow));

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
   import vtg_pkg::*;
#(
   parameter int FIELD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               step,
   input  logic [FIELD_W-1:0] len_act,
   input  logic [FIELD_W-1:0] len_front,
   input  logic [FIELD_W-1:0] len_sync,
   input  logic [FIELD_W-1:0] len_back,
   output logic [FIELD_W+1:0] cnt,
   output seg_e               seg,
   output logic               at_last,
   output logic               at_act_end
);

   localparam int CNT_W = FIELD_W + 2;

   logic [CNT_W-1:0] end_act;
   logic [CNT_W-1:0] end_front;
   logic [CNT_W-1:0] end_sync;
   logic [CNT_W-1:0] end_back;

   // Each field holds length-1, so every segment adds field+1 positions.
   always_comb begin
      end_act   = CNT_W'(len_act);
      end_front = end_act   + CNT_W'(len_front) + CNT_W'(1);
      end_sync  = end_front + CNT_W'(len_sync)  + CNT_W'(1);
      end_back  = end_sync  + CNT_W'(len_back)  + CNT_W'(1);
   end

   always_comb begin
      if (cnt <= end_act)        seg = SEG_ACTIVE;
      else if (cnt <= end_front) seg = SEG_FRONT;
      else if (cnt <= end_sync)  seg = SEG_SYNC;
      else                       seg = SEG_BACK;
   end

   assign at_last    = (cnt == end_back);
   assign at_act_end = (cnt == end_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= at_last ? '0 : cnt + CNT_W'(1);
      end
   end

   // R3: the position never passes the end of the back porch
   p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= end_back));

   // R6: a stopped axis restarts from its first active position
   p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/vtg_irq.sv
module vtg_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_evt,
   input  logic glb_en,
   input  logic frm_en,
   input  logic clr,
   output logic pending
);

   logic set_now;

   assign set_now = frame_evt && glb_en && frm_en;

   // A new event in the same cycle as a clear wins, so none is lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pending <= 1'b0;
      else if (set_now) pending <= 1'b1;
      else if (clr)     pending <= 1'b0;
   end

   // R7: pending can only become set while both enables are on
   p_set_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(glb_en && frm_en));

   // R8: a clear with no competing event empties the pending bit
   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_now) |=> !pending);

endmodule

// File: rtl/vtg_top.sv
module vtg_top
   import vtg_pkg::*;
#(
   parameter int FIELD_W = 12,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              frame_irq
);

   localparam int CNT_W  = FIELD_W + 2;
   localparam int AX_H   = 0;
   localparam int AX_V   = 1;
   localparam int MAP_SZ = FIELD_BASE + NUM_AXES * AXIS_FIELDS;

   if (FIELD_W < 1) begin : g_bad_field
      $error("vtg_top: FIELD_W must be at least 1");
   end
   if (DATA_W < FIELD_W || DATA_W < 2) begin : g_bad_data
      $error("vtg_top: DATA_W too narrow for a size field");
   end
   if ((1 << ADDR_W) < MAP_SZ) begin : g_bad_addr
      $error("vtg_top: ADDR_W cannot reach every register");
   end

   logic video_en, frame_en, irq_glb_en, irq_frm_en, pend_clr;
   logic running, frame_wrap, frame_load, irq_evt;
   logic [NUM_AXES-1:0][AXIS_FIELDS-1:0][FIELD_W-1:0] shadow;
   logic [NUM_AXES-1:0] step, at_last, at_act_end;
   logic [CNT_W-1:0]    cnt [NUM_AXES];
   seg_e                seg [NUM_AXES];

   vtg_regs #(
      .FIELD_W (FIELD_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .frame_load (frame_load),
      .video_en   (video_en),
      .frame_en   (frame_en),
      .irq_glb_en (irq_glb_en),
      .irq_frm_en (irq_frm_en),
      .pend_clr   (pend_clr),
      .shadow     (shadow)
   );

   assign running = video_en && frame_en;

   // Axis 0 advances every pixel; each further axis advances when all the
   // axes below it wrap.
   for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_ax
      if (ax == 0) begin : g_first
         assign step[ax] = 1'b1;
      end else begin : g_chain
         assign step[ax] = step[ax-1] && at_last[ax-1];
      end

      vtg_axis #(
         .FIELD_W (FIELD_W)
      ) u_axis (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (running),
         .step       (step[ax]),
         .len_act    (shadow[ax][F_ACT]),
         .len_front  (shadow[ax][F_FRONT]),
         .len_sync   (shadow[ax][F_SYNC]),
         .len_back   (shadow[ax][F_BACK]),
         .cnt        (cnt[ax]),
         .seg        (seg[ax]),
         .at_last    (at_last[ax]),
         .at_act_end (at_act_end[ax])
      );
   end

   assign frame_wrap = running && (&at_last);
   assign frame_load = !running || frame_wrap;

   // Last pixel of the last active line: pending shows from the next pixel.
   assign irq_evt = running && at_last[AX_H] && at_act_end[AX_V];

   vtg_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_evt (irq_evt),
      .glb_en    (irq_glb_en),
      .frm_en    (irq_frm_en),
      .clr       (pend_clr),
      .pending   (frame_irq)
   );

   assign hsync = running && (seg[AX_H] == SEG_SYNC);
   assign vsync = running && (seg[AX_V] == SEG_SYNC);
   assign de    = running && (seg[AX_H] == SEG_ACTIVE) && (seg[AX_V] == SEG_ACTIVE);

   // R3: sync never overlaps the displayed region
   p_de_not_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!hsync && !vsync));

   // R7: the interrupt appears at the first pixel of the first porch line
   p_irq_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_irq) |-> (cnt[AX_H] == '0 && seg[AX_V] == SEG_FRONT));

   // R5: without both enables the outputs stay quiet
   p_quiet_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(video_en && frame_en)) && !running |-> !(hsync || vsync || de));

endmodule

// File: tb/vtg_top_bench.sv
module vtg_top_bench;

   typedef struct {
      string lbl;
      int    period;
      int    de_n;
      int    hs_n;
      int    vs_n;
      int    hs_off;
      int    vs_off;
      int    irq_off;
   } frame_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        drv_en = 1'b0;
   logic [3:0]  drv_addr = '0;
   logic [15:0] drv_data = '0;
   logic        clr_req = 1'b0;
   logic        clr_go;
   logic        wr_en;
   logic [3:0]  wr_addr;
   logic [15:0] wr_data;
   logic        hsync, vsync, de, frame_irq;

   int     n_checks = 0;
   int     n_fail = 0;
   int     cyc = 0;
   int     frames_done = 0;
   bit     armed = 1'b0;
   bit     auto_clr = 1'b0;
   bit     done = 1'b0;
   bit     clr_fired = 1'b0;
   frame_t exp_q[$];

   always #5 clk = ~clk;

   assign clr_go  = clr_req && !drv_en;
   assign wr_en   = drv_en || clr_go;
   assign wr_addr = drv_en ? drv_addr : 4'd2;
   assign wr_data = drv_en ? drv_data : 16'd1;

   vtg_top u_vtg_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .hsync     (hsync),
      .vsync     (vsync),
      .de        (de),
      .frame_irq (frame_irq)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      drv_en   = 1'b1;
      drv_addr = 4'(addr);
      drv_data = 16'(data);
      @(negedge clk);
      drv_en   = 1'b0;
   endtask

   // Sizes given as true lengths; fields are written as length minus one.
   task automatic program_sizes(input int ha, input int hf, input int hs, input int hb,
                                input int va, input int vf, input int vs, input int vb);
      wr(4, ha - 1);  wr(5, hf - 1);  wr(6, hs - 1);  wr(7, hb - 1);
      wr(8, va - 1);  wr(9, vf - 1);  wr(10, vs - 1); wr(11, vb - 1);
   endtask

   function automatic frame_t expect_frame(input string lbl,
                                           input int ha, input int hf, input int hs, input int hb,
                                           input int va, input int vf, input int vs, input int vb,
                                           input bit irq_on);
      frame_t f;
      int ht, vt;
      ht = ha + hf + hs + hb;
      vt = va + vf + vs + vb;
      f.lbl     = lbl;
      f.period  = ht * vt;
      f.de_n    = ha * va;
      f.hs_n    = hs * vt;
      f.vs_n    = vs * ht;
      f.hs_off  = ha + hf;
      f.vs_off  = (va + vf) * ht;
      f.irq_off = irq_on ? va * ht : -1;
      return f;
   endfunction

   task automatic quiet_window(input string req, input int cycles);
      int hits;
      hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (hsync || vsync || de) hits++;
      end
      check_eq(req, "active outputs while stopped", hits, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      clr_fired = clr_go;
   end

   // Monitor: summarises each frame from its first de cycle to the next.
   initial begin : monitor
      bit     in_frame, saw_vs, p_de, p_hs, p_vs, p_irq;
      int     t0, c_de, c_hs, c_vs, o_hs, o_vs, o_irq;
      frame_t e;
      in_frame = 0; saw_vs = 1; p_de = 0; p_hs = 0; p_vs = 0; p_irq = 0;
      t0 = 0; c_de = 0; c_hs = 0; c_vs = 0; o_hs = -1; o_vs = -1; o_irq = -1;
      forever begin
         @(negedge clk);
         if (clr_req && clr_fired) clr_req = 1'b0;
         if (!armed) begin
            in_frame = 0; saw_vs = 1; clr_req = 1'b0;
         end else begin
            if (de && !p_de && saw_vs) begin
               if (in_frame) begin
                  if (exp_q.size() == 0) begin
                     check_eq("R2", "unexpected frame", 1, 0);
                  end else begin
                     e = exp_q.pop_front();
                     check_eq("R4", {e.lbl, " frame length"}, cyc - t0, e.period);
                     check_eq("R2", {e.lbl, " de cycles"}, c_de, e.de_n);
                     check_eq("R3", {e.lbl, " hsync cycles"}, c_hs, e.hs_n);
                     check_eq("R4", {e.lbl, " vsync cycles"}, c_vs, e.vs_n);
                     check_eq("R3", {e.lbl, " hsync offset"}, o_hs, e.hs_off);
                     check_eq("R4", {e.lbl, " vsync offset"}, o_vs, e.vs_off);
                     check_eq("R7", {e.lbl, " irq offset"}, o_irq, e.irq_off);
                  end
                  frames_done++;
               end
               in_frame = 1; saw_vs = 0; t0 = cyc;
               c_de = 0; c_hs = 0; c_vs = 0; o_hs = -1; o_vs = -1; o_irq = -1;
               if (auto_clr) clr_req = 1'b1;
            end
            if (in_frame) begin
               c_de += int'(de);
               c_hs += int'(hsync);
               c_vs += int'(vsync);
               if (hsync && !p_hs && o_hs < 0) o_hs = cyc - t0;
               if (vsync && !p_vs && o_vs < 0) o_vs = cyc - t0;
               if (frame_irq && !p_irq && o_irq < 0) o_irq = cyc - t0;
            end
            if (vsync) saw_vs = 1;
         end
         p_de = de; p_hs = hsync; p_vs = vsync; p_irq = frame_irq;
      end
   end

   initial begin : watchdog
      wait (cyc >= 150000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : driver
      int base;
      repeat (4) @(negedge clk);
      // R1: reset state
      check_eq("R1", "hsync after reset", int'(hsync), 0);
      check_eq("R1", "vsync after reset", int'(vsync), 0);
      check_eq("R1", "de after reset", int'(de), 0);
      check_eq("R1", "frame_irq after reset", int'(frame_irq), 0);
      rst_n = 1'b1;
      quiet_window("R1", 20);

      // Geometry A, interrupts fully enabled
      program_sizes(16, 4, 3, 5, 6, 2, 2, 3);
      wr(1, 3);
      // R5: one enable alone keeps the output stopped
      wr(0, 1);
      quiet_window("R5", 60);
      wr(0, 2);
      quiet_window("R5", 60);
      wr(0, 0);

      auto_clr = 1'b1;
      armed    = 1'b1;
      base     = frames_done;
      exp_q.push_back(expect_frame("A", 16, 4, 3, 5, 6, 2, 2, 3, 1));
      exp_q.push_back(expect_frame("A (R9 written mid-frame)", 16, 4, 3, 5, 6, 2, 2, 3, 1));
      wr(0, 3);
      // R6: first running cycle is the first active pixel
      check_eq("R6", "de on restart", int'(de), 1);

      wait (frames_done >= base + 1);
      repeat (100) @(negedge clk);
      // R9: geometry B written during frame 2 must first appear in frame 3
      program_sizes(10, 2, 4, 3, 4, 1, 3, 2);
      exp_q.push_back(expect_frame("B (R9)", 10, 2, 4, 3, 4, 1, 3, 2, 1));
      exp_q.push_back(expect_frame("B", 10, 2, 4, 3, 4, 1, 3, 2, 1));
      wait (frames_done >= base + 4);
      armed = 1'b0;
      check_eq("R9", "expected frames left over", exp_q.size(), 0);
      wr(0, 0);
      quiet_window("R5", 50);

      // Geometry C: every field zero; interrupt frame enable cleared (R7)
      wr(1, 1);
      program_sizes(1, 1, 1, 1, 1, 1, 1, 1);
      armed = 1'b1;
      base  = frames_done;
      exp_q.push_back(expect_frame("C minimum", 1, 1, 1, 1, 1, 1, 1, 1, 0));
      exp_q.push_back(expect_frame("C minimum", 1, 1, 1, 1, 1, 1, 1, 1, 0));
      exp_q.push_back(expect_frame("C minimum", 1, 1, 1, 1, 1, 1, 1, 1, 0));
      wr(0, 3);
      check_eq("R6", "de on restart, minimum sizes", int'(de), 1);
      wait (frames_done >= base + 3);
      armed = 1'b0;
      check_eq("R7", "expected frames left over", exp_q.size(), 0);
      wr(0, 0);
      check_eq("R7", "no pending with frame enable clear", int'(frame_irq), 0);

      // R8: write-one-to-clear on the pending bit
      auto_clr = 1'b0;
      program_sizes(16, 4, 3, 5, 6, 2, 2, 3);
      wr(1, 3);
      wr(0, 3);
      for (int i = 0; i < 2000 && !frame_irq; i++) @(negedge clk);
      check_eq("R7", "pending set after last active line", int'(frame_irq), 1);
      wr(2, 0);
      check_eq("R8", "pending after writing zero", int'(frame_irq), 1);
      wr(2, 1);
      check_eq("R8", "pending after writing one", int'(frame_irq), 0);
      repeat (5) @(negedge clk);
      check_eq("R8", "pending stays clear", int'(frame_irq), 0);
      wr(0, 0);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule